// File: doc/BRIEF.md
# Data Access Fault Checker

This block sits between a data-side address generator and the rest of the memory pipeline. Each request carries a virtual address, an access size, a write flag, privilege state and a few address-space class flags. In the same cycle the block returns the lookup address to an external translation buffer. That buffer answers with hit status and the attributes of the hit page. One cycle later the block gives either a physical address with an uncacheable flag, or a single fault code. A fault code comes with a status-write strobe.

Faults are resolved by a fixed priority, so exactly one code is reported. For translation faults the block also produces a tag word for the fault-address register, built from the effective virtual page and the context number. A hypervisor access through the implicit address space skips translation: its address passes straight through the implemented physical width.

Top module: `dacc_fault_chk`

## Requirements
- R1: An access is misaligned when `va_i & ((1 << size_log2_i) - 1)` is nonzero (1, 2, 4 or 8 bytes). It reports fault code 1, and this beats every other fault and the hypervisor bypass.
- R2: When `addr_mask_i` is set, `lkup_va_o` carries `va_i[31:0]` zero-extended to 64 bits in the same cycle. The hole check is skipped, and the tag word is built from the masked address. Otherwise `lkup_va_o` equals `va_i`.
- R3: An unmasked address inside the inclusive range [HOLE_LO, HOLE_HI] reports code 2. This is checked after misalignment and before the translation result.
- R4: A translation miss reports code 3 when the access is real (`asi_real_i` set or `mmu_en_i` clear). Otherwise it reports code 4.
- R5: On a hit, a non-privileged access (`priv_i` low) to a privileged page reports code 5.
- R6: Next in priority, a write to a page without write permission reports code 6.
- R7: Next in priority, code 7 is reported in two cases: a no-fault-only page accessed without a no-fault class, or a side-effect page accessed with a no-fault class.
- R8: A clean translated access reports code 0 with `pa_o = pte_pa_i`. `uncache_o` is set when the page has side effects or bit UC_BIT (39) of the physical address is set.
- R9: An aligned access with `hpriv_i` and `asi_implicit_i` both set reports code 0. Its `pa_o` is the low PA_W bits of the effective address, `uncache_o` is 0, and the translation result is ignored.
- R10: Responses appear exactly one cycle after `req_valid_i`. `fsr_we_o` is high for one cycle exactly when the response carries a nonzero code. With no request, every output is 0.
- R11: `tag_we_o` is raised with `tag_o = {eff_va[63:13], ctx_i}` for codes 3 to 7 only. Otherwise `tag_o` is 0.
- R12: During and right after reset, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| va_i | input | 64 | Virtual address |
| size_log2_i | input | 2 | log2 of access size in bytes |
| write_i | input | 1 | Store access |
| priv_i | input | 1 | Supervisor privilege |
| hpriv_i | input | 1 | Hypervisor privilege |
| addr_mask_i | input | 1 | 32-bit address masking enabled |
| mmu_en_i | input | 1 | Data translation enabled |
| asi_implicit_i | input | 1 | Implicit address-space class |
| asi_real_i | input | 1 | Real (untranslated-context) class |
| asi_nofault_i | input | 1 | No-fault class |
| ctx_i | input | 13 | Context number for the tag word |
| lkup_va_o | output | 64 | Effective address for translation lookup |
| tlb_hit_i | input | 1 | Lookup hit |
| pte_priv_i | input | 1 | Page is privileged |
| pte_write_i | input | 1 | Page is writable |
| pte_nofault_i | input | 1 | Page allows no-fault accesses only |
| pte_side_i | input | 1 | Page has side effects |
| pte_pa_i | input | PA_W | Translated physical address |
| rsp_valid_o | output | 1 | Response valid |
| fault_o | output | 3 | Fault code, 0 = none |
| pa_o | output | PA_W | Physical address (0 on fault) |
| uncache_o | output | 1 | Access must bypass caches |
| fsr_we_o | output | 1 | Fault status write strobe |
| tag_we_o | output | 1 | Fault tag write strobe |
| tag_o | output | 64 | Fault tag word |

## Verification
The hardest situations to reach are the ones where several fault conditions hold at once. Only the priority order decides the reported code: a misaligned address inside the hole, a hypervisor bypass over a missing translation, or a masked address whose upper half lies in the hole. Directed cases build each of these overlaps explicitly, along with the inclusive hole edges. The random phase then draws addresses near both hole bounds and sets every page attribute and class flag independently, so the stacked conditions occur often.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_RANGE = 3'd2,
    FLT_RMISS = 3'd3,
    FLT_VMISS = 3'd4,
    FLT_PRIV  = 3'd5,
    FLT_PROT  = 3'd6,
    FLT_ATTR  = 3'd7
  } flt_e;
  localparam int VA_W  = 64;
  localparam int CTX_W = 13;
  localparam int PG_LSB = 13;
endpackage

// File: rtl/dacc_addr_stage.sv
module dacc_addr_stage
  import dacc_pkg::*;
#(
  parameter int          MASK_W  = 32,
  parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      size_log2_i,
  input  logic            addr_mask_i,
  input  logic            hpriv_i,
  input  logic            implicit_i,
  output logic [VA_W-1:0] va_eff_o,
  output logic            misalign_o,
  output logic            in_hole_o,
  output logic            bypass_o
);
  localparam int SZ_W = 8;
  logic [SZ_W-1:0] sz_mask;
  logic [VA_W-1:0] va_trunc;

  generate
    if (MASK_W < VA_W) begin : g_trunc
      assign va_trunc = {{(VA_W-MASK_W){1'b0}}, va_i[MASK_W-1:0]};
    end else begin : g_full
      assign va_trunc = va_i;
    end
  endgenerate

  always_comb begin
    sz_mask    = (SZ_W'(1) << size_log2_i) - SZ_W'(1);
    misalign_o = |(va_i[SZ_W-1:0] & sz_mask);
    va_eff_o   = addr_mask_i ? va_trunc : va_i;
    // masked addresses never land in the hole
    in_hole_o  = !addr_mask_i && (va_i >= HOLE_LO) && (va_i <= HOLE_HI);
    bypass_o   = hpriv_i && implicit_i && !misalign_o;
  end
endmodule

// File: rtl/dacc_fault_sel.sv
module dacc_fault_sel
  import dacc_pkg::*;
(
  input  logic misalign_i,
  input  logic in_hole_i,
  input  logic bypass_i,
  input  logic hit_i,
  input  logic real_i,
  input  logic priv_i,
  input  logic write_i,
  input  logic nofault_asi_i,
  input  logic pte_priv_i,
  input  logic pte_write_i,
  input  logic pte_nofault_i,
  input  logic pte_side_i,
  output flt_e code_o,
  output logic rec_tag_o
);
  always_comb begin
    rec_tag_o = 1'b1;
    if (misalign_i) begin
      code_o = FLT_ALIGN; rec_tag_o = 1'b0;
    end else if (bypass_i) begin
      code_o = FLT_NONE;  rec_tag_o = 1'b0;
    end else if (in_hole_i) begin
      code_o = FLT_RANGE; rec_tag_o = 1'b0;
    end else if (!hit_i) begin
      code_o = real_i ? FLT_RMISS : FLT_VMISS;
    end else if (!priv_i && pte_priv_i) begin
      code_o = FLT_PRIV;
    end else if (write_i && !pte_write_i) begin
      code_o = FLT_PROT;
    end else if ((pte_nofault_i && !nofault_asi_i) || (pte_side_i && nofault_asi_i)) begin
      code_o = FLT_ATTR;
    end else begin
      code_o = FLT_NONE;  rec_tag_o = 1'b0;
    end
  end
endmodule

// File: rtl/dacc_fault_chk.sv
module dacc_fault_chk
  import dacc_pkg::*;
#(
  parameter int          PA_W    = 40,
  parameter int          UC_BIT  = 39,
  parameter int          MASK_W  = 32,
  parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [63:0]      va_i,
  input  logic [1:0]       size_log2_i,
  input  logic             write_i,
  input  logic             priv_i,
  input  logic             hpriv_i,
  input  logic             addr_mask_i,
  input  logic             mmu_en_i,
  input  logic             asi_implicit_i,
  input  logic             asi_real_i,
  input  logic             asi_nofault_i,
  input  logic [12:0]      ctx_i,
  output logic [63:0]      lkup_va_o,
  input  logic             tlb_hit_i,
  input  logic             pte_priv_i,
  input  logic             pte_write_i,
  input  logic             pte_nofault_i,
  input  logic             pte_side_i,
  input  logic [PA_W-1:0]  pte_pa_i,
  output logic             rsp_valid_o,
  output logic [2:0]       fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             uncache_o,
  output logic             fsr_we_o,
  output logic             tag_we_o,
  output logic [63:0]      tag_o
);
  logic [VA_W-1:0] va_eff;
  logic misalign, in_hole, bypass, rec_tag;
  flt_e code;
  logic [PA_W-1:0] pa_d;
  logic uc_d;

  dacc_addr_stage #(.MASK_W(MASK_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_addr (
    .va_i(va_i), .size_log2_i(size_log2_i), .addr_mask_i(addr_mask_i),
    .hpriv_i(hpriv_i), .implicit_i(asi_implicit_i),
    .va_eff_o(va_eff), .misalign_o(misalign), .in_hole_o(in_hole), .bypass_o(bypass)
  );

  dacc_fault_sel u_sel (
    .misalign_i(misalign), .in_hole_i(in_hole), .bypass_i(bypass),
    .hit_i(tlb_hit_i), .real_i(asi_real_i || !mmu_en_i),
    .priv_i(priv_i), .write_i(write_i), .nofault_asi_i(asi_nofault_i),
    .pte_priv_i(pte_priv_i), .pte_write_i(pte_write_i),
    .pte_nofault_i(pte_nofault_i), .pte_side_i(pte_side_i),
    .code_o(code), .rec_tag_o(rec_tag)
  );

  assign lkup_va_o = va_eff;

  always_comb begin
    pa_d = '0;
    uc_d = 1'b0;
    if (code == FLT_NONE) begin
      if (bypass) begin
        pa_d = va_eff[PA_W-1:0];
      end else begin
        pa_d = pte_pa_i;
        uc_d = pte_side_i || pte_pa_i[UC_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fault_o     <= '0;
      pa_o        <= '0;
      uncache_o   <= 1'b0;
      fsr_we_o    <= 1'b0;
      tag_we_o    <= 1'b0;
      tag_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      fault_o     <= req_valid_i ? code : FLT_NONE;
      pa_o        <= req_valid_i ? pa_d : '0;
      uncache_o   <= req_valid_i && uc_d;
      fsr_we_o    <= req_valid_i && (code != FLT_NONE);
      tag_we_o    <= req_valid_i && rec_tag;
      tag_o       <= (req_valid_i && rec_tag) ? {va_eff[VA_W-1:PG_LSB], ctx_i} : '0;
    end
  end

  assert_align_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && misalign |=> fault_o == FLT_ALIGN);
  assert_mask_no_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && addr_mask_i |=> fault_o != FLT_RANGE);
  assert_uc_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncache_o |-> rsp_valid_o && fault_o == FLT_NONE);
  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && bypass |=> fault_o == FLT_NONE && !uncache_o);
  assert_rsp_timing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> fault_o == FLT_NONE && !fsr_we_o && !tag_we_o);
  assert_tag_codes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> fsr_we_o && fault_o >= FLT_RMISS);
endmodule

// File: tb/dacc_fault_chk_test.sv
module dacc_fault_chk_test;
  localparam int PA_W = 40;
  localparam logic [63:0] LO = 64'h0000_8000_0000_0000;
  localparam logic [63:0] HI = 64'hFFFF_7FFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req, wr, pv, hp, am, me, imp, rl, anf, hit, pp, pw, pn, ps;
  logic [63:0] va;
  logic [1:0]  sz;
  logic [12:0] ctx;
  logic [PA_W-1:0] ppa;
  logic [63:0] lkup, tag;
  logic rsp, uc, fwe, twe;
  logic [2:0] flt;
  logic [PA_W-1:0] pa;

  int checks = 0, fails = 0, cyc = 0;

  dacc_fault_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .va_i(va), .size_log2_i(sz),
    .write_i(wr), .priv_i(pv), .hpriv_i(hp), .addr_mask_i(am), .mmu_en_i(me),
    .asi_implicit_i(imp), .asi_real_i(rl), .asi_nofault_i(anf), .ctx_i(ctx),
    .lkup_va_o(lkup), .tlb_hit_i(hit), .pte_priv_i(pp), .pte_write_i(pw),
    .pte_nofault_i(pn), .pte_side_i(ps), .pte_pa_i(ppa),
    .rsp_valid_o(rsp), .fault_o(flt), .pa_o(pa), .uncache_o(uc),
    .fsr_we_o(fwe), .tag_we_o(twe), .tag_o(tag)
  );

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic clear_in();
    req = 0; va = '0; sz = 0; wr = 0; pv = 0; hp = 0; am = 0; me = 1; imp = 0;
    rl = 0; anf = 0; ctx = '0; hit = 0; pp = 0; pw = 0; pn = 0; ps = 0; ppa = '0;
  endtask

  task automatic go();
    logic [63:0] veff;
    logic mis, hole, byp, tw, euc;
    logic [2:0] ec;
    logic [PA_W-1:0] epa;
    string rq;
    veff = am ? {32'b0, va[31:0]} : va;
    mis  = (va & ((64'd1 << sz) - 64'd1)) != 0;
    hole = !am && veff >= LO && veff <= HI;
    byp  = hp && imp && !mis;
    if (mis) ec = 3'd1;
    else if (byp) ec = 3'd0;
    else if (hole) ec = 3'd2;
    else if (!hit) ec = (rl || !me) ? 3'd3 : 3'd4;
    else if (!pv && pp) ec = 3'd5;
    else if (wr && !pw) ec = 3'd6;
    else if ((pn && !anf) || (ps && anf)) ec = 3'd7;
    else ec = 3'd0;
    epa = (ec == 0) ? (byp ? veff[PA_W-1:0] : ppa) : '0;
    euc = (ec == 0) && !byp && (ps || ppa[39]);
    tw  = ec >= 3;
    case (ec)
      3'd0: rq = byp ? "R9" : "R8";
      3'd1: rq = "R1";
      3'd2: rq = "R3";
      3'd3, 3'd4: rq = "R4";
      3'd5: rq = "R5";
      3'd6: rq = "R6";
      default: rq = "R7";
    endcase
    req = 1;
    #1;
    chk(lkup == veff, "R2", "lkup_va", lkup, veff);
    @(posedge clk);
    @(negedge clk);
    chk(rsp == 1'b1, "R10", "rsp_valid", 64'(rsp), 64'd1);
    chk(flt == ec, rq, "fault", 64'(flt), 64'(ec));
    chk(pa == epa && uc == euc, rq, "pa/uncache", {23'b0, uc, pa}, {23'b0, euc, epa});
    chk(fwe == (ec != 0), "R10", "fsr_we", 64'(fwe), 64'(ec != 0));
    chk(twe == tw && tag == (tw ? {veff[63:13], ctx} : 64'd0), "R11", "tag",
        tag, tw ? {veff[63:13], ctx} : 64'd0);
    req = 0;
  endtask

  task automatic idle_chk();
    @(posedge clk);
    @(negedge clk);
    chk(!rsp && flt == 0 && pa == 0 && !uc && !fwe && !twe && tag == 0, "R10",
        "idle outputs", {57'b0, rsp, uc, fwe, twe, flt == 0, pa == 0, tag == 0}, 64'h7);
  endtask

  initial begin
    clear_in();
    void'($urandom(32'h5eed_1234));
    #1;
    chk(!rsp && flt == 0 && pa == 0 && !fwe && !twe && tag == 0, "R12", "in reset",
        {60'b0, rsp, fwe, twe, flt != 0}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp && flt == 0 && !uc && !fwe, "R12", "after reset", {61'b0, rsp, uc, fwe}, 64'd0);

    // misaligned inside hole, with bypass set: R1 wins
    va = LO + 64'h2; sz = 2'd3; hp = 1; imp = 1; go(); clear_in();
    va = 64'h1001; sz = 2'd1; hit = 1; pw = 1; go(); clear_in();
    va = 64'h1004; sz = 2'd2; hit = 1; ppa = 40'h12_3456_7000; go(); clear_in();
    // hole edges R3
    va = LO; hit = 1; go(); clear_in();
    va = LO - 64'd8; sz = 2'd3; hit = 1; go(); clear_in();
    va = HI; hit = 1; go(); clear_in();
    va = HI + 64'd1; sz = 2'd3; hit = 1; go(); clear_in();
    // masked hole address R2
    va = 64'h8000_0000_DEAD_B000; am = 1; ctx = 13'h1abc; go(); clear_in();
    va = 64'h8000_0000_DEAD_B000; am = 1; hit = 1; ppa = 40'h00_0000_1000; go(); clear_in();
    // misses R4
    va = 64'h4000; rl = 1; ctx = 13'h5; go(); clear_in();
    va = 64'h4000; me = 0; go(); clear_in();
    va = 64'h4000; me = 1; ctx = 13'h1fff; go(); clear_in();
    // privilege R5
    va = 64'h6000; hit = 1; pp = 1; go(); clear_in();
    va = 64'h6000; hit = 1; pp = 1; pv = 1; ppa = 40'h00_0000_6000; go(); clear_in();
    // write protection R6
    va = 64'h7000; hit = 1; wr = 1; go(); clear_in();
    va = 64'h7000; hit = 1; wr = 1; pp = 1; go(); clear_in();
    // attribute R7
    va = 64'h8000; hit = 1; pn = 1; go(); clear_in();
    va = 64'h8000; hit = 1; ps = 1; anf = 1; go(); clear_in();
    va = 64'h8000; hit = 1; pn = 1; anf = 1; ppa = 40'h00_0000_8000; go(); clear_in();
    // uncacheable R8
    va = 64'h9000; hit = 1; ps = 1; ppa = 40'h00_0000_9000; go(); clear_in();
    va = 64'h9000; hit = 1; ppa = 40'h80_0000_9000; go(); clear_in();
    // bypass R9 over miss and hole
    va = LO + 64'h40; hp = 1; imp = 1; go(); clear_in();
    va = 64'hFFFF_FFFF_1234_5678; hp = 1; imp = 1; am = 1; go(); clear_in();
    va = 64'h100; hp = 1; imp = 0; go(); clear_in();
    idle_chk();

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: va = {32'b0, $urandom};
        2'd1: va = LO + 64'($urandom % 64);
        2'd2: va = HI - 64'($urandom % 64);
        default: va = {$urandom, $urandom};
      endcase
      if (r[2]) va[2:0] = 3'b0;
      sz = r[4:3]; wr = r[5]; pv = r[6]; hp = r[7] & r[8]; am = r[9] & r[10];
      me = r[11] | r[12]; imp = r[13]; rl = r[14] & r[15]; anf = r[16] & r[17];
      hit = r[18] | r[19]; pp = r[20] & r[21]; pw = r[22] | r[23];
      pn = r[24] & r[25]; ps = r[26] & r[27]; ctx = 13'($urandom);
      ppa = {8'($urandom), $urandom};
      go();
      if (r[31:29] == 3'd0) idle_chk();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule